// File: doc/BRIEF.md
# Vertical-interval bias calibration sequencer

The block counts horizontal sync pulses during each vertical retrace interval and, from that count, produces a fixed schedule of single-bit control pulses for an external cathode-bias calibration loop. The loop itself (summing node, transconductance stage, hold capacitor) lives outside. Only the line counting and the pulse schedule are built here.

After a vertical edge, the first thirteen lines stay quiet. A blanking window then forces the video drive to black for seven lines. Inside that window a three-line setup phase comes first, and a measurement phase follows. During measurement the grid pulse is high, the program pulse is low, and the external hold stage is enabled. Both sync inputs are asynchronous. Each passes through a two-stage synchronizer and a rising-edge detector. The counter saturates after the schedule ends, so each vertical interval runs the sequence once.

Top module: `vbias_seq_top`

## Requirements
- R1: Out of reset, and until the first vertical rising edge, the outputs sit at idle: blank_o=0, setup_o=0, grid_o=0, prog_o=1, sample_o=0. Horizontal pulses do not change this.
- R2: A vertical rising edge restarts the line count at zero. The first 13 horizontal pulses after it leave every output at idle.
- R3: blank_o is high after the 14th through the 20th horizontal pulse (7 lines) and falls at the 21st.
- R4: setup_o is high after the 15th, 16th and 17th horizontal pulse only.
- R5: grid_o and sample_o are high after the 18th, 19th and 20th horizontal pulse only.
- R6: prog_o is low exactly while grid_o is high and high at all other times, including during setup.
- R7: Once the count reaches 21 it saturates. Further horizontal pulses produce no output activity until the next vertical edge.
- R8: A vertical rising edge arriving mid-sequence returns all outputs to idle, and the schedule restarts from line zero.
- R9: When vertical and horizontal rising edges reach the counter in the same cycle, the vertical edge wins and that horizontal pulse is not counted.
- R10: An input rising edge changes the outputs on the third clock edge after the input rises (two synchronizer stages, then the counter register).
- R11: Only rising edges count. A vertical input held high does not restart the count again, and a horizontal input held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical retrace input, asynchronous |
| hsync_i | input | 1 | Horizontal sync input, asynchronous |
| blank_o | output | 1 | Black-level blanking window |
| setup_o | output | 1 | Setup phase indication |
| grid_o | output | 1 | Grid pulse, high during measurement |
| prog_o | output | 1 | Program pulse, low during measurement |
| sample_o | output | 1 | Hold-stage update enable |

## Verification
The bench restarts a vertical interval, steps through 25 horizontal pulses, and checks all five outputs after every line. This separates off-by-one errors at each phase boundary from saturation errors. A second sweep injects a vertical edge after every line count from 1 to 21 and then replays a full sequence. This shows whether the abort returns every output to idle and whether counting restarts cleanly. Further patterns cover the following cases:
- horizontal pulses before any vertical edge;
- coincident vertical and horizontal edges;
- a vertical input held high across the whole interval;
- a horizontal input held high;
- a cycle-exact probe of the synchronizer latency.

// File: rtl/vbias_pkg.sv
package vbias_pkg;
  function automatic logic in_window(int unsigned cnt, int unsigned first, int unsigned len);
    return (cnt >= first) && (cnt < first + len);
  endfunction
endpackage

// File: rtl/vbias_sync_edge.sv
module vbias_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vbias_line_cnt.sv
module vbias_line_cnt #(
  parameter int unsigned LAST  = 21,
  parameter int unsigned CNT_W = $clog2(LAST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vs_edge_i,
  input  logic             hs_edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LAST);

  // reset to the saturated value so nothing fires before the first vertical edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= CNT_SAT;
    else if (vs_edge_i)                  cnt_o <= '0;
    else if (hs_edge_i && cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/vbias_decode.sv
module vbias_decode
  import vbias_pkg::*;
#(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned BLANK_FIRST = 14,
  parameter int unsigned BLANK_LINES = 7,
  parameter int unsigned SETUP_FIRST = 15,
  parameter int unsigned SETUP_LINES = 3,
  parameter int unsigned GRID_FIRST  = 18
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             blank_o,
  output logic             setup_o,
  output logic             grid_o,
  output logic             prog_o,
  output logic             sample_o
);
  localparam int unsigned GRID_LINES = BLANK_FIRST + BLANK_LINES - GRID_FIRST;

  logic meas;

  always_comb begin
    blank_o  = in_window(int'(cnt_i), BLANK_FIRST, BLANK_LINES);
    setup_o  = in_window(int'(cnt_i), SETUP_FIRST, SETUP_LINES);
    meas     = in_window(int'(cnt_i), GRID_FIRST, GRID_LINES);
    grid_o   = meas;
    prog_o   = ~meas;
    sample_o = meas;
  end
endmodule

// File: rtl/vbias_seq_top.sv
module vbias_seq_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLANK_FIRST = 14,
  parameter int unsigned BLANK_LINES = 7,
  parameter int unsigned SETUP_FIRST = 15,
  parameter int unsigned SETUP_LINES = 3,
  parameter int unsigned GRID_FIRST  = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic hsync_i,
  output logic blank_o,
  output logic setup_o,
  output logic grid_o,
  output logic prog_o,
  output logic sample_o
);
  localparam int unsigned LAST  = BLANK_FIRST + BLANK_LINES;
  localparam int unsigned CNT_W = $clog2(LAST + 1);

  logic [1:0]       async_in;
  logic [1:0]       rise;
  logic             vs_edge, hs_edge;
  logic [CNT_W-1:0] line_cnt;

  assign async_in = {hsync_i, vsync_i};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_in
      vbias_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(async_in[i]),
        .rise_o (rise[i])
      );
    end
  endgenerate

  assign vs_edge = rise[0];
  assign hs_edge = rise[1];

  vbias_line_cnt #(.LAST(LAST), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vs_edge_i(vs_edge),
    .hs_edge_i(hs_edge),
    .cnt_o    (line_cnt)
  );

  vbias_decode #(
    .CNT_W      (CNT_W),
    .BLANK_FIRST(BLANK_FIRST),
    .BLANK_LINES(BLANK_LINES),
    .SETUP_FIRST(SETUP_FIRST),
    .SETUP_LINES(SETUP_LINES),
    .GRID_FIRST (GRID_FIRST)
  ) u_dec (
    .cnt_i   (line_cnt),
    .blank_o (blank_o),
    .setup_o (setup_o),
    .grid_o  (grid_o),
    .prog_o  (prog_o),
    .sample_o(sample_o)
  );
endmodule

// File: rtl/vbias_seq_chk.sv
module vbias_seq_chk #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LAST  = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vs_edge,
  input logic             hs_edge,
  input logic [CNT_W-1:0] line_cnt,
  input logic             blank_o,
  input logic             setup_o,
  input logic             grid_o,
  input logic             prog_o,
  input logic             sample_o
);
  AST_VS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_edge |=> (!blank_o && !setup_o && !grid_o && prog_o && !sample_o)); // R8
  AST_VS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_edge |=> (line_cnt == '0)); // R9
  AST_SETUP_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o |-> (blank_o && !grid_o)); // R4
  AST_GRID_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_o |-> (blank_o && sample_o)); // R5
  AST_PROG_OPPOSITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o != grid_o)); // R6
  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vs_edge && !hs_edge) |=> $stable(line_cnt)); // R11
  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt == CNT_W'(LAST) && !vs_edge) |=> (line_cnt == CNT_W'(LAST))); // R7
  AST_BLANK_ONLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blank_o) |-> (!setup_o && !grid_o)); // R3
endmodule

bind vbias_seq_top vbias_seq_chk #(.CNT_W(CNT_W), .LAST(LAST)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vs_edge (vs_edge),
  .hs_edge (hs_edge),
  .line_cnt(line_cnt),
  .blank_o (blank_o),
  .setup_o (setup_o),
  .grid_o  (grid_o),
  .prog_o  (prog_o),
  .sample_o(sample_o)
);

// File: tb/sim_vbias_seq_top.sv
module sim_vbias_seq_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vsync = 1'b0;
  logic hsync = 1'b0;
  logic blank, setup, grid, prog, sample;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  vbias_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vsync), .hsync_i(hsync),
    .blank_o(blank), .setup_o(setup), .grid_o(grid), .prog_o(prog), .sample_o(sample)
  );

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b (blank,setup,grid,prog,sample)", req, got, exp);
    end
  endtask

  function automatic logic [4:0] model(int n);
    logic b, s, g;
    b = (n >= 14) && (n <= 20);
    s = (n >= 15) && (n <= 17);
    g = (n >= 18) && (n <= 20);
    return {b, s, g, ~g, g};
  endfunction

  function automatic logic [4:0] outs();
    return {blank, setup, grid, prog, sample};
  endfunction

  task automatic clks(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_v();
    vsync = 1'b1; clks(2); vsync = 1'b0; clks(2);
  endtask

  task automatic pulse_h();
    hsync = 1'b1; clks(2); hsync = 1'b0; clks(2);
  endtask

  initial begin
    clks(3);
    chk("R1 reset idle", outs(), model(0));
    rst_ni = 1'b1;
    clks(2);
    for (int i = 0; i < 16; i++) pulse_h();
    chk("R1 idle before first vertical edge", outs(), model(0));

    // full sweep, check after every line
    pulse_v();
    chk("R2 line 0", outs(), model(0));
    for (int n = 1; n <= 25; n++) begin
      pulse_h();
      if (n <= 13)      chk("R2 quiet lines", outs(), model(n));
      else if (n <= 14) chk("R3 blank start", outs(), model(n));
      else if (n <= 17) chk("R4 setup lines", outs(), model(n));
      else if (n <= 20) chk("R5 R6 measurement lines", outs(), model(n));
      else              chk("R7 saturated", outs(), model(n));
    end

    // abort after every line count, then full replay
    for (int k = 1; k <= 21; k++) begin
      pulse_v();
      for (int n = 0; n < k; n++) pulse_h();
      pulse_v();
      chk("R8 abort idle", outs(), model(0));
      for (int n = 1; n <= 21; n++) begin
        pulse_h();
        if (n == 14 || n == 15 || n == 18 || n == 21)
          chk("R8 restart schedule", outs(), model(n));
      end
    end

    // coincident vertical and horizontal edges
    vsync = 1'b1; hsync = 1'b1; clks(2); vsync = 1'b0; hsync = 1'b0; clks(2);
    for (int n = 0; n < 13; n++) pulse_h();
    chk("R9 coincident hsync not counted", outs(), model(13));
    pulse_h();
    chk("R9 blank on 14th counted", outs(), model(14));

    // latency probe: vertical edge while blank high
    vsync = 1'b1;
    clks(2);
    chk("R10 no change after two edges", outs(), model(14));
    clks(1);
    chk("R10 idle after third edge", outs(), model(0));
    // vertical held high: no further restarts
    for (int n = 1; n <= 15; n++) pulse_h();
    chk("R11 vertical held high line 15", outs(), model(15));
    vsync = 1'b0; clks(2);
    // horizontal held high counts once
    pulse_v();
    for (int n = 0; n < 13; n++) pulse_h();
    hsync = 1'b1; clks(20);
    chk("R11 held hsync counts once", outs(), model(14));
    hsync = 1'b0; clks(2);
    pulse_h();
    chk("R11 next pulse line 15", outs(), model(15));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        clks(150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule